// File: doc/BRIEF.md
# Raw Sensor Pixel Correction Pipeline

This block takes raw 12-bit pixels from an image sensor as a valid/ready stream in raster order. It applies four early corrections in a fixed sequence. First it removes the black level. Next it maps each pixel through a programmable lens-compensation table. It then substitutes an interpolated value at listed defective sensor sites. Last it scales each pixel by a white-balance gain chosen by the pixel's Bayer colour. The result leaves on a matching valid/ready stream, and each pixel carries its own start-of-frame and end-of-line flags.

The frame geometry is taken from the stream markers. A pixel flagged start-of-frame is row 0, column 0. The column count returns to zero after each pixel flagged end-of-line, and the row count then increments.

A write-only configuration port holds the correction parameters:

| cfg_sel | Contents |
|---|---|
| 0 | black level |
| 1 | lens table entries |
| 2 | defect coordinates |
| 3 | the four colour gains |

Top module: `pixel_corr_pipe`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 while out_ready is 1, every gain is unity (0x100), the black level is 0 and no defect entry is enabled.
- R2: The stage subtracts the black level (cfg_sel=0, cfg_wdata[11:0]) from every pixel. A pixel at or below the black level becomes 0 rather than wrapping.
- R3: The black-corrected value indexes the lens table through its upper LUT_AW bits (value >> (12-LUT_AW)). Table entry i is written with cfg_sel=1, cfg_idx=i and cfg_wdata[11:0].
- R4: A defect entry k is written with cfg_sel=2 and cfg_idx=k. Its fields are cfg_wdata[24] for enable, [23:12] for row and [11:0] for column. When a pixel position matches an enabled entry, the pixel becomes floor((L+R)/2), where L and R are the lens-table outputs two columns to the left and right on the same line.
- R5: A defect in column 0 or 1 uses only its right neighbour. A defect in one of the last two columns of its line uses only its left neighbour.
- R6: The white-balance result is min(4095, (v*g + 128) >> 8), where g is an unsigned 4.8 gain. The gain index is {row[0], col[0]}, and gain j is written with cfg_sel=3, cfg_idx=j and cfg_wdata[11:0].
- R7: The corrections apply in order: black level, lens table, defect interpolation on lens-table outputs, then gain.
- R8: out_sof and out_eol arrive with the same pixel that carried them at the input.
- R9: While out_valid is 1 and out_ready is 0, the outputs hold steady and in_ready is 0. No pixel is lost or duplicated.
- R10: In the cycle after a pixel flagged end-of-line is accepted, in_ready is 0. The line is then drained by three internal padding slots.
- R11: A defect entry whose enable bit is 0 does not alter the pixel at its coordinates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 12 | Raw pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take a pixel |
| out_pix | output | 12 | Corrected pixel |
| out_sof | output | 1 | Start-of-frame flag of this pixel |
| out_eol | output | 1 | End-of-line flag of this pixel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 black, 1 lens table, 2 defect, 3 gain |
| cfg_idx | input | LUT_AW | Entry index within the target |
| cfg_wdata | input | 25 | Write data |

## Verification
On every cycle, the assertions check that:
- the output is frozen and the input is refused during backpressure;
- the input closes for the cycle after a line end;
- the output is idle after reset.

The values themselves can only be checked by the bench's frames. These frames cover saturating subtraction, table indexing, mid-line and edge defect interpolation, disabled entries, gain rounding and clipping, and marker alignment. The bench compares them in order against a model that does not depend on latency.

// File: rtl/pixel_corr_pkg.sv
package pixel_corr_pkg;
    localparam int PIX_W     = 12;
    localparam int CRD_W     = 12;
    localparam int GAIN_W    = 12;
    localparam int GAIN_FRAC = 8;
    localparam int CFG_W     = 2 * CRD_W + 1;

    localparam logic [1:0] SEL_BLACK = 2'd0;
    localparam logic [1:0] SEL_LUT   = 2'd1;
    localparam logic [1:0] SEL_DEF   = 2'd2;
    localparam logic [1:0] SEL_GAIN  = 2'd3;

    // one slot of the pipeline; pad marks a line-drain filler
    typedef struct packed {
        logic             vld;
        logic             pad;
        logic             sof;
        logic             eol;
        logic [CRD_W-1:0] row;
        logic [CRD_W-1:0] col;
        logic [PIX_W-1:0] pix;
    } tok_t;
endpackage

// File: rtl/pcp_lens_lut.sv
module pcp_lens_lut
    import pixel_corr_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [PIX_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [PIX_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
        if (rd_en)
            rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/pcp_defect_match.sv
module pcp_defect_match
    import pixel_corr_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [$clog2(N_ENT)-1:0] wr_idx,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [CRD_W-1:0] row,
    input  logic [CRD_W-1:0] col,
    output logic             hit
);
    localparam int IW = $clog2(N_ENT);

    logic [N_ENT-1:0] match;

    for (genvar k = 0; k < N_ENT; k++) begin : g_ent
        logic             en_q;
        logic [CRD_W-1:0] row_q;
        logic [CRD_W-1:0] col_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q  <= 1'b0;
                row_q <= '0;
                col_q <= '0;
            end else if (wr_en && wr_idx == IW'(k)) begin
                en_q  <= wr_data[2*CRD_W];
                row_q <= wr_data[2*CRD_W-1:CRD_W];
                col_q <= wr_data[CRD_W-1:0];
            end
        end

        assign match[k] = en_q && row_q == row && col_q == col;
    end

    assign hit = |match;
endmodule

// File: rtl/pcp_wb_gain.sv
module pcp_wb_gain
    import pixel_corr_pkg::*;
(
    input  logic [PIX_W-1:0]  pix,
    input  logic [GAIN_W-1:0] gain,
    output logic [PIX_W-1:0]  res
);
    localparam int PROD_W = PIX_W + GAIN_W + 1;
    localparam int SC_W   = PROD_W - GAIN_FRAC;

    logic [PROD_W-1:0] prod;
    logic [SC_W-1:0]   scaled;

    always_comb begin
        prod   = PROD_W'(pix) * PROD_W'(gain) + PROD_W'(1 << (GAIN_FRAC - 1));
        scaled = SC_W'(prod >> GAIN_FRAC);
        if (scaled > SC_W'({PIX_W{1'b1}}))
            res = '1;
        else
            res = scaled[PIX_W-1:0];
    end
endmodule

// File: rtl/pixel_corr_pipe.sv
module pixel_corr_pipe
    import pixel_corr_pkg::*;
#(
    parameter int LUT_AW   = 10,
    parameter int N_DEFECT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic              in_sof,
    input  logic              in_eol,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_pix,
    output logic              out_sof,
    output logic              out_eol,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [LUT_AW-1:0] cfg_idx,
    input  logic [CFG_W-1:0]  cfg_wdata
);
    localparam int DEF_IW = $clog2(N_DEFECT);
    localparam int WIN_N  = 5;
    localparam int CTR    = WIN_N / 2;
    localparam logic [1:0] PAD_N = 2'd3;

    typedef struct packed {
        tok_t                   s1;
        tok_t                   s2;
        tok_t [WIN_N-1:0]       win;
        tok_t                   s3;
        tok_t                   s4;
        logic [1:0]             pend;
        logic [CRD_W-1:0]       row;
        logic [CRD_W-1:0]       col;
        logic [PIX_W-1:0]       black;
        logic [3:0][GAIN_W-1:0] gain;
    } state_t;

    state_t q, d;

    logic             en;
    logic [PIX_W-1:0] lut_rdata;
    logic             def_hit;
    logic [PIX_W-1:0] wb_res;

    pcp_lens_lut #(.AW(LUT_AW)) u_lut (
        .clk     (clk),
        .wr_en   (cfg_we && cfg_sel == SEL_LUT),
        .wr_addr (cfg_idx),
        .wr_data (cfg_wdata[PIX_W-1:0]),
        .rd_en   (en),
        .rd_addr (q.s1.pix[PIX_W-1 -: LUT_AW]),
        .rd_data (lut_rdata)
    );

    pcp_defect_match #(.N_ENT(N_DEFECT)) u_def (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && cfg_sel == SEL_DEF),
        .wr_idx  (cfg_idx[DEF_IW-1:0]),
        .wr_data (cfg_wdata),
        .row     (q.win[CTR].row),
        .col     (q.win[CTR].col),
        .hit     (def_hit)
    );

    pcp_wb_gain u_wb (
        .pix  (q.s3.pix),
        .gain (q.gain[{q.s3.row[0], q.s3.col[0]}]),
        .res  (wb_res)
    );

    always_comb begin
        logic             acc;
        logic [CRD_W-1:0] r_cur, c_cur;
        logic [PIX_W-1:0] sub;
        logic             l_ok, r_ok;
        logic [PIX_W:0]   sum;
        logic [PIX_W-1:0] fixed;
        tok_t             nt;

        d        = q;
        en       = !q.s4.vld || out_ready;
        in_ready = en && q.pend == 2'd0;
        acc      = in_valid && in_ready;

        sub   = (in_pix > q.black) ? in_pix - q.black : '0;
        r_cur = in_sof ? '0 : q.row;
        c_cur = in_sof ? '0 : q.col;

        if (cfg_we && cfg_sel == SEL_BLACK)
            d.black = cfg_wdata[PIX_W-1:0];
        if (cfg_we && cfg_sel == SEL_GAIN)
            d.gain[cfg_idx[1:0]] = cfg_wdata[GAIN_W-1:0];

        if (acc) begin
            d.col = in_eol ? '0 : c_cur + 1'b1;
            d.row = in_eol ? r_cur + 1'b1 : r_cur;
        end

        // neighbours two columns away; pads keep lines apart
        l_ok = q.win[WIN_N-1].vld && !q.win[WIN_N-1].pad;
        r_ok = q.win[0].vld && !q.win[0].pad;
        sum  = {1'b0, q.win[WIN_N-1].pix} + {1'b0, q.win[0].pix};
        if (!def_hit)
            fixed = q.win[CTR].pix;
        else if (l_ok && r_ok)
            fixed = sum[PIX_W:1];
        else if (l_ok)
            fixed = q.win[WIN_N-1].pix;
        else if (r_ok)
            fixed = q.win[0].pix;
        else
            fixed = q.win[CTR].pix;

        nt     = q.s2;
        nt.pix = lut_rdata;

        if (en) begin
            d.s1 = '0;
            if (q.pend != 2'd0) begin
                d.s1.vld = 1'b1;
                d.s1.pad = 1'b1;
                d.pend   = q.pend - 1'b1;
            end else if (acc) begin
                d.s1.vld = 1'b1;
                d.s1.sof = in_sof;
                d.s1.eol = in_eol;
                d.s1.row = r_cur;
                d.s1.col = c_cur;
                d.s1.pix = sub;
                if (in_eol)
                    d.pend = PAD_N;
            end
            d.s2 = q.s1;
            d.s3 = '0;
            if (q.s2.vld) begin
                d.win[0] = nt;
                for (int i = 1; i < WIN_N; i++)
                    d.win[i] = q.win[i-1];
                if (q.win[CTR].vld && !q.win[CTR].pad) begin
                    d.s3     = q.win[CTR];
                    d.s3.pix = fixed;
                end
            end
            d.s4     = q.s3;
            d.s4.pix = wb_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.gain <= {4{GAIN_W'(1 << GAIN_FRAC)}};
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.s4.vld;
    assign out_pix   = q.s4.pix;
    assign out_sof   = q.s4.sof;
    assign out_eol   = q.s4.eol;
endmodule

// File: rtl/pixel_corr_pipe_chk.sv
module pixel_corr_pipe_chk
    import pixel_corr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_eol,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_pix,
    input logic             out_sof,
    input logic             out_eol
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix)
                                    && $stable(out_sof) && $stable(out_eol));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R10
    line_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_eol |=> !in_ready);
endmodule

bind pixel_corr_pipe pixel_corr_pipe_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eol    (in_eol),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .out_sof   (out_sof),
    .out_eol   (out_eol)
);

// File: tb/pixel_corr_pipe_test.sv
`timescale 1ns/1ps
module pixel_corr_pipe_test;
    localparam int LUT_AW = 10;
    localparam int W = 16;
    localparam int H = 4;
    localparam int NPIX = W * H;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
    logic [11:0] in_pix = '0;
    logic in_ready, out_valid, out_sof, out_eol;
    logic out_ready = 1'b1;
    logic [11:0] out_pix;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [LUT_AW-1:0] cfg_idx = '0;
    logic [24:0] cfg_wdata = '0;

    int checks = 0, failures = 0;

    int raw [NPIX];
    int exp_pix [NPIX];
    int lutm [1 << LUT_AW];
    int gm [4];
    int blk;
    int d_en [16], d_row [16], d_col [16];

    pixel_corr_pipe #(.LUT_AW(LUT_AW), .N_DEFECT(16)) uut (.*);

    always #4 clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic cfg_wr(logic [1:0] s, int idx, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_idx = LUT_AW'(idx); cfg_wdata = 25'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_defect(int k, int en, int r, int c);
        d_en[k] = en; d_row[k] = r; d_col[k] = c;
        cfg_wr(2'd2, k, (en << 24) | (r << 12) | c);
    endtask

    function automatic void build_exp();
        int l [NPIX];
        for (int i = 0; i < NPIX; i++) begin
            int b = raw[i] > blk ? raw[i] - blk : 0;
            l[i] = lutm[b >> (12 - LUT_AW)];
        end
        for (int i = 0; i < NPIX; i++) begin
            int r = i / W, c = i % W, v = l[i], hit = 0, g, o;
            for (int k = 0; k < 16; k++)
                if (d_en[k] != 0 && d_row[k] == r && d_col[k] == c) hit = 1;
            if (hit != 0) begin
                if (c >= 2 && c + 2 < W) v = (l[i-2] + l[i+2]) / 2;
                else if (c >= 2) v = l[i-2];
                else if (c + 2 < W) v = l[i+2];
            end
            g = gm[(r % 2) * 2 + (c % 2)];
            o = (v * g + 128) >> 8;
            exp_pix[i] = o > 4095 ? 4095 : o;
        end
    endfunction

    task automatic run_frame(string tag, int rdy_pct);
        int ii = 0, oi = 0, cyc = 0, sp = 0;
        bit eolacc = 0, stl = 0, accd = 0;
        build_exp();
        while (oi < NPIX && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (accd) in_valid = 1'b0;
            accd = 0;
            out_ready = ($urandom % 100) < rdy_pct;
            if (!in_valid && ii < NPIX && ($urandom % 4) != 0) begin
                in_valid = 1'b1;
                in_pix   = 12'(raw[ii]);
                in_sof   = (ii == 0);
                in_eol   = (ii % W) == W - 1;
            end
            #1;
            if (eolacc) check(!in_ready, "R10 in_ready after eol", int'(in_ready), 0);
            eolacc = 0;
            if (stl) check(out_valid && int'(out_pix) == sp, "R9 stalled output held",
                           int'(out_pix), sp);
            stl = out_valid && !out_ready;
            sp  = int'(out_pix);
            if (in_valid && in_ready) begin
                eolacc = in_eol;
                accd   = 1;
                ii++;
            end
            if (out_valid && out_ready) begin
                check(int'(out_pix) == exp_pix[oi], {tag, " pixel"}, int'(out_pix), exp_pix[oi]);
                check(out_sof == (oi == 0) && out_eol == ((oi % W) == W - 1),
                      "R8 markers", {out_sof, out_eol}, {(oi == 0), ((oi % W) == W - 1)});
                oi++;
            end
        end
        @(negedge clk);
        if (accd) in_valid = 1'b0;
        check(oi == NPIX, "R9 output count", oi, NPIX);
        out_ready = 1'b1;
        repeat (10) @(negedge clk);
        check(!out_valid, "R9 no extra pixel", int'(out_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 16; k++) begin d_en[k] = 0; d_row[k] = 0; d_col[k] = 0; end
        for (int j = 0; j < 4; j++) gm[j] = 256;
        blk = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
        check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);

        // Frame A: default gains, saturating black level, linear table
        blk = 100;
        cfg_wr(2'd0, 0, blk);
        for (int i = 0; i < (1 << LUT_AW); i++) begin
            lutm[i] = i * 4 + 2;
            cfg_wr(2'd1, i, lutm[i]);
        end
        for (int i = 0; i < NPIX; i++) raw[i] = $urandom % 4096;
        raw[0] = 0; raw[1] = 50; raw[2] = 100; raw[3] = 101; raw[4] = 4095;
        run_frame("R1,R2,R3", 80);

        // Frame B: defects at mid, edges, a disabled one; varied gains
        for (int i = 0; i < (1 << LUT_AW); i++) begin
            lutm[i] = (i * 37 + 11) % 4096;
            cfg_wr(2'd1, i, lutm[i]);
        end
        gm[0] = 256; gm[1] = 384; gm[2] = 200; gm[3] = 4095;
        for (int j = 0; j < 4; j++) cfg_wr(2'd3, j, gm[j]);
        set_defect(0, 1, 1, 5);
        set_defect(1, 1, 2, 0);
        set_defect(2, 1, 3, 15);
        set_defect(3, 1, 2, 14);
        set_defect(4, 0, 0, 7);
        for (int i = 0; i < NPIX; i++) raw[i] = $urandom % 4096;
        raw[W + 5] = 4095;
        raw[7] = 0;
        run_frame("R4,R5,R6,R7,R11", 70);

        // Frame C: heavy backpressure, one more defect
        blk = 37;
        cfg_wr(2'd0, 0, blk);
        set_defect(5, 1, 0, 1);
        for (int i = 0; i < NPIX; i++) raw[i] = $urandom % 4096;
        run_frame("R6,R7,R9", 25);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule